// File: doc/BRIEF.md
# Retirement PC Continuity Monitor

This synthesizable monitor sits beside a processor's instruction retirement trace. It confirms that program-counter values chain correctly from one retired instruction to the next. Every retirement channel reports a valid bit, a 64-bit sequence index, the PC the instruction executed from, the PC that follows it, and a flag saying that the instruction was entered through an interrupt. Retirements are paired by sequence index rather than by arrival cycle. Several channels may retire in one cycle, and retirements may arrive out of order.

The monitor is used inside a bounded window. It is held in reset first, and then a one-cycle `trig` pulse picks a reference retirement. Two checks run at the same time. The forward check looks for the retirement whose index is one above the reference and compares that retirement's current PC with the reference's next PC. The backward check looks for the retirement whose index is one below the reference and compares that retirement's next PC with the reference's current PC. A `chk` pulse in the last cycle of the window turns any mismatch seen so far into a sticky error output.

Top module: `retire_pc_monitor`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `errFwd` and `errBwd` are 0.
- R2: After a trigger on retirement K, a retirement with index K+1 whose current PC differs from K's next PC makes `errFwd` 1 in the cycle after `chk`. A retirement with a matching PC leaves `errFwd` at 0.
- R3: Pairing is by sequence index on any channel. The partner may appear in the trigger cycle itself or in any later cycle before `chk`. Retirements with any other index have no effect.
- R4: The forward comparison is skipped when retirement K+1 has its interrupt flag set to 1.
- R5: A retirement with index K-1 whose next PC differs from the reference's current PC makes `errBwd` 1 in the cycle after `chk`. Matching PCs leave `errBwd` at 0.
- R6: The backward comparison is skipped when the reference retirement K has its interrupt flag set to 1.
- R7: The error outputs change only in the cycle after `chk` is high. If no partner was seen by that point, no error is raised.
- R8: Once an error output is 1, it stays 1 until reset. After the first `chk`, further triggers and checks have no effect.
- R9: A trigger in a cycle with no valid retirement is ignored. When several channels are valid in the trigger cycle, the lowest-numbered one is the reference.
- R10: Index arithmetic wraps modulo 2^64, so the successor of index 2^64-1 is index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Selects the reference retirement in this cycle |
| chk | input | 1 | Evaluates the window in this cycle |
| retValid | input | NCHAN | Per-channel retirement valid |
| retOrder | input | NCHAN*64 | Per-channel sequence index, channel i at bits [64*i +: 64] |
| retPcCur | input | NCHAN*XLEN | Per-channel PC before execution |
| retPcNext | input | NCHAN*XLEN | Per-channel PC after execution |
| retIntr | input | NCHAN | Per-channel interrupt-entry flag |
| errFwd | output | 1 | Sticky forward continuity error |
| errBwd | output | 1 | Sticky backward continuity error |

## Verification
Errors are latched into sticky bits, so a corrupted reference register or mismatch bit does not show at once. It appears at the outputs one cycle after `chk`, as a spurious or missing error. For that reason every scenario samples both outputs just before the `chk` edge and again just after it. Scenarios place the partner retirement in the trigger cycle, one cycle later, and several cycles later. This exposes a reference register that is not held between the trigger and the partner. Wrong pairing or a wrong interrupt exemption shows up as a flipped error bit within the same window.

// File: rtl/pcmon_pkg.sv
package pcmon_pkg;
  localparam int ORDW = 64;

  typedef enum logic [1:0] {
    MON_IDLE  = 2'd0,
    MON_WATCH = 2'd1,
    MON_DONE  = 2'd2
  } monState_t;

  typedef struct packed {
    logic capture;
    logic watch;
  } ctlStrb_t;
endpackage

// File: rtl/pcmon_dpath.sv
module pcmon_dpath #(
  parameter int XLEN  = 32,
  parameter int NCHAN = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  pcmon_pkg::ctlStrb_t           strb,
  input  logic [NCHAN-1:0]              retValid,
  input  logic [NCHAN*pcmon_pkg::ORDW-1:0] retOrder,
  input  logic [NCHAN*XLEN-1:0]         retPcCur,
  input  logic [NCHAN*XLEN-1:0]         retPcNext,
  input  logic [NCHAN-1:0]              retIntr,
  output logic                          refFound,
  output logic                          fwdBad,
  output logic                          bwdBad
);
  localparam int OW = pcmon_pkg::ORDW;

  logic [OW-1:0]   capOrd, refOrdQ, activeOrd, succOrd, predOrd;
  logic [XLEN-1:0] capCur, capNext, refCurQ, refNextQ, activeCur, activeNext;
  logic            capIntr, refIntrQ, activeIntr;
  logic [NCHAN-1:0] fwdMis, bwdMis;
  logic            cmpEn, fwdSeenQ, bwdSeenQ;

  // Lowest-numbered valid channel is the reference candidate (R9)
  always_comb begin
    refFound = 1'b0;
    capOrd   = '0;
    capCur   = '0;
    capNext  = '0;
    capIntr  = 1'b0;
    for (int i = 0; i < NCHAN; i++) begin
      if (!refFound && retValid[i]) begin
        refFound = 1'b1;
        capOrd   = retOrder[i*OW +: OW];
        capCur   = retPcCur[i*XLEN +: XLEN];
        capNext  = retPcNext[i*XLEN +: XLEN];
        capIntr  = retIntr[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      refOrdQ  <= '0;
      refCurQ  <= '0;
      refNextQ <= '0;
      refIntrQ <= 1'b0;
    end else if (strb.capture) begin
      refOrdQ  <= capOrd;
      refCurQ  <= capCur;
      refNextQ <= capNext;
      refIntrQ <= capIntr;
    end
  end

  // In the trigger cycle the fresh capture is compared directly
  assign activeOrd  = strb.capture ? capOrd  : refOrdQ;
  assign activeCur  = strb.capture ? capCur  : refCurQ;
  assign activeNext = strb.capture ? capNext : refNextQ;
  assign activeIntr = strb.capture ? capIntr : refIntrQ;
  assign succOrd    = activeOrd + OW'(1);
  assign predOrd    = activeOrd - OW'(1);
  assign cmpEn      = strb.capture | strb.watch;

  for (genvar g = 0; g < NCHAN; g++) begin : gChan
    logic [OW-1:0]   chOrd;
    logic [XLEN-1:0] chCur, chNext;
    assign chOrd  = retOrder[g*OW +: OW];
    assign chCur  = retPcCur[g*XLEN +: XLEN];
    assign chNext = retPcNext[g*XLEN +: XLEN];
    assign fwdMis[g] = retValid[g] && !retIntr[g] && (chOrd == succOrd) &&
                       (chCur != activeNext);
    assign bwdMis[g] = retValid[g] && !activeIntr && (chOrd == predOrd) &&
                       (chNext != activeCur);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwdSeenQ <= 1'b0;
      bwdSeenQ <= 1'b0;
    end else if (cmpEn) begin
      fwdSeenQ <= fwdSeenQ | (|fwdMis);
      bwdSeenQ <= bwdSeenQ | (|bwdMis);
    end
  end

  assign fwdBad = fwdSeenQ | (cmpEn & (|fwdMis));
  assign bwdBad = bwdSeenQ | (cmpEn & (|bwdMis));

  AST_REF_ORDER_HELD: assert property (@(posedge clk) disable iff (rst)
    !strb.capture |=> $stable(refOrdQ)); // R3
  AST_REF_PC_HELD: assert property (@(posedge clk) disable iff (rst)
    !strb.capture |=> ($stable(refNextQ) && $stable(refCurQ))); // R3
  AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (rst)
    fwdSeenQ |=> fwdSeenQ); // R8
endmodule

// File: rtl/pcmon_ctrl.sv
module pcmon_ctrl (
  input  logic                clk,
  input  logic                rst,
  input  logic                trig,
  input  logic                chk,
  input  logic                refFound,
  input  logic                fwdBad,
  input  logic                bwdBad,
  output pcmon_pkg::ctlStrb_t strb,
  output logic                errFwd,
  output logic                errBwd
);
  import pcmon_pkg::*;

  monState_t stateQ, stateD;
  logic      evaluate, errFwdQ, errBwdQ;

  always_comb begin
    strb.capture = (stateQ == MON_IDLE) && trig && refFound;
    strb.watch   = (stateQ == MON_WATCH);
    evaluate     = chk && (strb.capture || strb.watch);
    stateD       = stateQ;
    if (evaluate)          stateD = MON_DONE;
    else if (strb.capture) stateD = MON_WATCH;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ  <= MON_IDLE;
      errFwdQ <= 1'b0;
      errBwdQ <= 1'b0;
    end else begin
      stateQ  <= stateD;
      errFwdQ <= errFwdQ | (evaluate & fwdBad);
      errBwdQ <= errBwdQ | (evaluate & bwdBad);
    end
  end

  assign errFwd = errFwdQ;
  assign errBwd = errBwdQ;

  AST_FWD_STICKY: assert property (@(posedge clk) disable iff (rst)
    errFwdQ |=> errFwdQ); // R8
  AST_BWD_STICKY: assert property (@(posedge clk) disable iff (rst)
    errBwdQ |=> errBwdQ); // R8
  AST_FWD_ON_CHECK: assert property (@(posedge clk) disable iff (rst)
    $rose(errFwdQ) |-> $past(chk)); // R7
  AST_BWD_ON_CHECK: assert property (@(posedge clk) disable iff (rst)
    $rose(errBwdQ) |-> $past(chk)); // R7
  AST_DONE_FINAL: assert property (@(posedge clk) disable iff (rst)
    (stateQ == MON_DONE) |=> (stateQ == MON_DONE)); // R8
endmodule

// File: rtl/retire_pc_monitor.sv
module retire_pc_monitor #(
  parameter int XLEN  = 32,
  parameter int NCHAN = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  trig,
  input  logic                  chk,
  input  logic [NCHAN-1:0]      retValid,
  input  logic [NCHAN*64-1:0]   retOrder,
  input  logic [NCHAN*XLEN-1:0] retPcCur,
  input  logic [NCHAN*XLEN-1:0] retPcNext,
  input  logic [NCHAN-1:0]      retIntr,
  output logic                  errFwd,
  output logic                  errBwd
);
  pcmon_pkg::ctlStrb_t strb;
  logic refFound, fwdBad, bwdBad;

  pcmon_ctrl u_ctrl (
    .clk(clk), .rst(rst), .trig(trig), .chk(chk),
    .refFound(refFound), .fwdBad(fwdBad), .bwdBad(bwdBad),
    .strb(strb), .errFwd(errFwd), .errBwd(errBwd)
  );

  pcmon_dpath #(.XLEN(XLEN), .NCHAN(NCHAN)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb),
    .retValid(retValid), .retOrder(retOrder), .retPcCur(retPcCur),
    .retPcNext(retPcNext), .retIntr(retIntr),
    .refFound(refFound), .fwdBad(fwdBad), .bwdBad(bwdBad)
  );

  AST_NO_ERR_AFTER_RESET: assert property (@(posedge clk)
    $fell(rst) |-> (!errFwd && !errBwd)); // R1
endmodule

// File: tb/retire_pc_monitor_tb.sv
module retire_pc_monitor_tb;
  localparam int XLEN = 32;
  localparam int NCH  = 2;

  logic clk = 1'b0;
  logic rst, trig, chk;
  logic [NCH-1:0]      retValid, retIntr;
  logic [NCH*64-1:0]   retOrder;
  logic [NCH*XLEN-1:0] retPcCur, retPcNext;
  logic errFwd, errBwd;
  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  retire_pc_monitor #(.XLEN(XLEN), .NCHAN(NCH)) u_dut (
    .clk(clk), .rst(rst), .trig(trig), .chk(chk),
    .retValid(retValid), .retOrder(retOrder), .retPcCur(retPcCur),
    .retPcNext(retPcNext), .retIntr(retIntr),
    .errFwd(errFwd), .errBwd(errBwd)
  );

  typedef struct packed {
    logic [63:0] ord;
    logic [31:0] cur, nxt;
    logic        rIntr;
    logic [63:0] nOrd;
    logic [31:0] nCur, nNxt;
    logic        nIntr;
    logic [3:0]  gap;
    logic        expF, expB;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{64'd10, 32'd100, 32'd104, 1'b0, 64'd11, 32'd104, 32'd108, 1'b0, 4'd1, 1'b0, 1'b0}, // R2
    '{64'd10, 32'd100, 32'd104, 1'b0, 64'd11, 32'd200, 32'd204, 1'b0, 4'd1, 1'b1, 1'b0}, // R2
    '{64'd10, 32'd100, 32'd104, 1'b0, 64'd11, 32'd200, 32'd204, 1'b1, 4'd2, 1'b0, 1'b0}, // R4
    '{64'd10, 32'd100, 32'd104, 1'b0, 64'd9,  32'd96,  32'd100, 1'b0, 4'd1, 1'b0, 1'b0}, // R5
    '{64'd10, 32'd100, 32'd104, 1'b0, 64'd9,  32'd92,  32'd96,  1'b0, 4'd1, 1'b0, 1'b1}, // R5
    '{64'd10, 32'd100, 32'd104, 1'b1, 64'd9,  32'd92,  32'd96,  1'b0, 4'd1, 1'b0, 1'b0}, // R6
    '{64'd10, 32'd100, 32'd104, 1'b0, 64'd12, 32'd999, 32'd1003,1'b0, 4'd1, 1'b0, 1'b0}, // R3
    '{64'd10, 32'd100, 32'd104, 1'b0, 64'd11, 32'd200, 32'd204, 1'b0, 4'd0, 1'b1, 1'b0}, // R3
    '{64'hFFFF_FFFF_FFFF_FFFF, 32'd100, 32'd104, 1'b0, 64'd0, 32'd8, 32'd12, 1'b0, 4'd1, 1'b1, 1'b0}, // R10
    '{64'd10, 32'd100, 32'd104, 1'b0, 64'd11, 32'd200, 32'd204, 1'b0, 4'd5, 1'b1, 1'b0}  // R3
  };

  function automatic string reqOf(int i);
    case (i)
      0, 1:    return "R2";
      2:       return "R4";
      3, 4:    return "R5";
      5:       return "R6";
      8:       return "R10";
      default: return "R3";
    endcase
  endfunction

  task automatic expect1(string req, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic clearIns();
    trig = 1'b0; chk = 1'b0;
    retValid = '0; retIntr = '0; retOrder = '0; retPcCur = '0; retPcNext = '0;
  endtask

  task automatic setCh(int ch, logic [63:0] o, logic [31:0] c, logic [31:0] n, logic intr);
    retValid[ch] = 1'b1;
    retIntr[ch]  = intr;
    retOrder[ch*64 +: 64]     = o;
    retPcCur[ch*XLEN +: XLEN]  = c;
    retPcNext[ch*XLEN +: XLEN] = n;
  endtask

  task automatic doReset();
    clearIns();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // chk is raised at a negedge; pre-edge and post-edge outputs are both sampled
  task automatic pulseCheck(string req, logic eF, logic eB);
    chk = 1'b1;
    expect1("R7", "errFwd before chk edge", errFwd, 1'b0);
    expect1("R7", "errBwd before chk edge", errBwd, 1'b0);
    @(negedge clk);
    chk = 1'b0;
    expect1(req, "errFwd", errFwd, eF);
    expect1(req, "errBwd", errBwd, eB);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    clearIns();
    rst = 1'b1;
    @(negedge clk);
    expect1("R1", "errFwd in reset", errFwd, 1'b0);
    expect1("R1", "errBwd in reset", errBwd, 1'b0);

    for (int i = 0; i < NV; i++) begin
      doReset();
      trig = 1'b1;
      setCh(0, VECS[i].ord, VECS[i].cur, VECS[i].nxt, VECS[i].rIntr);
      if (VECS[i].gap == 4'd0) setCh(1, VECS[i].nOrd, VECS[i].nCur, VECS[i].nNxt, VECS[i].nIntr);
      @(negedge clk);
      clearIns();
      if (VECS[i].gap != 4'd0) begin
        repeat (int'(VECS[i].gap) - 1) @(negedge clk);
        setCh(1, VECS[i].nOrd, VECS[i].nCur, VECS[i].nNxt, VECS[i].nIntr);
        @(negedge clk);
        clearIns();
      end
      pulseCheck(reqOf(i), VECS[i].expF, VECS[i].expB);
    end

    // R8: error survives later triggers and checks, clears on reset (R1)
    doReset();
    trig = 1'b1; setCh(0, 64'd50, 32'h40, 32'h44, 1'b0);
    @(negedge clk); clearIns();
    setCh(0, 64'd51, 32'h80, 32'h84, 1'b0);
    @(negedge clk); clearIns();
    pulseCheck("R2", 1'b1, 1'b0);
    trig = 1'b1; setCh(0, 64'd60, 32'h10, 32'h14, 1'b0);
    @(negedge clk); clearIns();
    setCh(0, 64'd59, 32'h0, 32'h4, 1'b0);
    @(negedge clk); clearIns();
    chk = 1'b1;
    @(negedge clk); clearIns();
    repeat (4) @(negedge clk);
    expect1("R8", "errFwd held", errFwd, 1'b1);
    expect1("R8", "errBwd unchanged after done", errBwd, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect1("R1", "errFwd cleared by reset", errFwd, 1'b0);

    // R9: trigger with no valid retirement is ignored
    doReset();
    trig = 1'b1;
    @(negedge clk);
    setCh(0, 64'd20, 32'd46, 32'd50, 1'b0);
    @(negedge clk); clearIns();
    setCh(0, 64'd21, 32'd60, 32'd64, 1'b0);
    @(negedge clk); clearIns();
    pulseCheck("R9", 1'b1, 1'b0);

    // R9: lowest valid channel is the reference
    doReset();
    trig = 1'b1;
    setCh(0, 64'd30, 32'd296, 32'd300, 1'b0);
    setCh(1, 64'd40, 32'd396, 32'd400, 1'b0);
    @(negedge clk); clearIns();
    setCh(0, 64'd31, 32'd400, 32'd404, 1'b0);
    @(negedge clk); clearIns();
    pulseCheck("R9", 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule